// File: doc/BRIEF.md
# Byte-Bus GPIO Port Bank

This block gives a small 8-bit core three general-purpose I/O ports behind a byte-wide register bus. Two of the ports are eight bits wide. Each of them has a data register, a configuration register and a read-only location that returns the pad levels. These three locations sit at consecutive addresses. The third port is a 4-bit output-only latch. Every pin of the wide ports gets its mode from one configuration bit and one data bit. That means the data bit doubles as the weak pull-up enable when the pin is an input.

The second wide port has two pins that are hard-wired as inputs, and configuration writes to them are discarded. Writing 1 to the top data bit of that port raises a one-cycle halt request to the core. Each pin of the wide ports also has an alternate-function enable. When it is set, a peripheral takes over the pad's output value and output enable. Reads are combinational from the address. Writes land on the clock edge at which the write strobe is sampled.

Top module: `gpio_portbank`

## Requirements
- R1: While `rstN` is low and after it is released, the data and configuration registers of ports A and B read 0x00, every A/B pad has output enable 0 and pull-up 0, `portCOut` is 4'b1111 and `haltReq` is 0.
- R2: For a pin whose alternate enable is 0, the pad output enable equals its configuration bit and the pad output value equals its data bit. The pull-up enable is 1 exactly when the configuration bit is 0 and the data bit is 1 (cfg/data 00 = high-Z input, 01 = pulled-up input, 10 = drive 0, 11 = drive 1).
- R3: Port A decodes its data register at 0xD0, its configuration register at 0xD1 and its pad-input location at 0xD2. A write is visible on reads and pads from the clock edge that samples `busWr`, and a read before that edge returns the old value.
- R4: Port B decodes its data register at 0xD4, its configuration register at 0xD5 and its pad-input location at 0xD6.
- R5: Port B bits 7 and 6 are input-only. Configuration writes to them are dropped, they read back 0 at 0xD5, and their pad output enable stays 0 even when the alternate function asks to drive.
- R6: A write to 0xD4 with bit 7 set makes `haltReq` high for exactly the one cycle after the write edge, and the bit is still stored. A write to 0xD4 with bit 7 clear, or a write of bit 7 to any other address, raises no request.
- R7: The output-only port's data register is at 0xDC. Its 4 bits drive `portCOut`, and a read returns them in bits 3:0 with bits 7:4 zero.
- R8: The pad-input locations 0xD2 and 0xD6 are read-only, and writes to them change no register. A read returns the pad level after a two-flop synchronizer, so a pad change shows up after the second clock edge.
- R9: With a pin's alternate enable at 1, the pad output enable and output value come from the alternate inputs and the pull-up is 0. The pad-input read still reflects the pad.
- R10: Reads of any address not listed above return 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, combinational from busAddr |
| padAIn | input | 8 | Port A pad levels |
| padAOe | output | 8 | Port A pad output enables |
| padAOut | output | 8 | Port A pad output values |
| padAPullEn | output | 8 | Port A weak pull-up enables |
| altAEn | input | 8 | Port A alternate-function enables |
| altAOut | input | 8 | Port A alternate output values |
| altAOe | input | 8 | Port A alternate output enables |
| padBIn | input | 8 | Port B pad levels |
| padBOe | output | 8 | Port B pad output enables |
| padBOut | output | 8 | Port B pad output values |
| padBPullEn | output | 8 | Port B weak pull-up enables |
| altBEn | input | 8 | Port B alternate-function enables |
| altBOut | input | 8 | Port B alternate output values |
| altBOe | input | 8 | Port B alternate output enables |
| portCOut | output | 4 | Output-only port C levels |
| haltReq | output | 1 | One-cycle halt request |

## Verification
Reads and the pad controls answer in the same cycle as their cause. The bench changes inputs one nanosecond after a rising edge and compares on the following falling edge. A register write is due on the first falling edge after the edge that samples `busWr`, and the halt pulse is due in that same cycle and gone one cycle later. A pad change is due only after the second rising edge, so the bench compares once after the first edge to confirm the old value and again after the second to confirm the new one. The driver queues each expected value with the cycle in which it must hold, and the monitor consumes the queue at the falling edge.

// File: rtl/gpio_portbank_pkg.sv
package gpio_portbank_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_A_DAT,
    RD_A_CFG,
    RD_A_PIN,
    RD_B_DAT,
    RD_B_CFG,
    RD_B_PIN,
    RD_C_DAT
  } rdSel_e;

  typedef struct packed {
    logic   wrADat;
    logic   wrACfg;
    logic   wrBDat;
    logic   wrBCfg;
    logic   wrCDat;
    logic   haltHit;
    rdSel_e rdSel;
  } ctrlStrb_t;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_portbank_pkg::*;
#(
  parameter int                 ADDR_W = 8,
  parameter logic [ADDR_W-1:0] A_BASE = 8'hD0,
  parameter logic [ADDR_W-1:0] B_BASE = 8'hD4,
  parameter logic [ADDR_W-1:0] C_ADDR = 8'hDC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              haltBitIn,
  output ctrlStrb_t         strb,
  output logic              haltReq
);

  localparam logic [ADDR_W-1:0] A_DAT = A_BASE;
  localparam logic [ADDR_W-1:0] A_CFG = A_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_PIN = A_BASE + ADDR_W'(2);
  localparam logic [ADDR_W-1:0] B_DAT = B_BASE;
  localparam logic [ADDR_W-1:0] B_CFG = B_BASE + ADDR_W'(1);
  localparam logic [ADDR_W-1:0] B_PIN = B_BASE + ADDR_W'(2);

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    case (busAddr)
      A_DAT: begin strb.rdSel = RD_A_DAT; strb.wrADat = busWr; end
      A_CFG: begin strb.rdSel = RD_A_CFG; strb.wrACfg = busWr; end
      A_PIN: strb.rdSel = RD_A_PIN;
      B_DAT: begin strb.rdSel = RD_B_DAT; strb.wrBDat = busWr; end
      B_CFG: begin strb.rdSel = RD_B_CFG; strb.wrBCfg = busWr; end
      B_PIN: strb.rdSel = RD_B_PIN;
      C_ADDR: begin strb.rdSel = RD_C_DAT; strb.wrCDat = busWr; end
      default: ;
    endcase
    strb.haltHit = strb.wrBDat & haltBitIn;
  end

  // halt pulse: one cycle, launched by the write edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) haltReq <= 1'b0;
    else       haltReq <= strb.haltHit;
  end

endmodule

// File: rtl/gpio_port_slice.sv
module gpio_port_slice #(
  parameter int           W           = 8,
  parameter logic [W-1:0] INONLY_MASK = '0,
  parameter int           SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrDat,
  input  logic         wrCfg,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] padIn,
  input  logic [W-1:0] altEn,
  input  logic [W-1:0] altOut,
  input  logic [W-1:0] altOe,
  output logic [W-1:0] datQ,
  output logic [W-1:0] cfgQ,
  output logic [W-1:0] pinQ,
  output logic [W-1:0] padOe,
  output logic [W-1:0] padOut,
  output logic [W-1:0] padPullEn
);

  localparam logic [W-1:0] CFG_KEEP = ~INONLY_MASK;

  logic [W-1:0] syncQ [SYNC_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      datQ <= '0;
      cfgQ <= '0;
    end else begin
      if (wrDat) datQ <= wdata;
      if (wrCfg) cfgQ <= wdata & CFG_KEEP;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end

  assign pinQ = syncQ[SYNC_STAGES-1];

  // per-pin mode and override mux
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign padOe[i]     = (altEn[i] ? altOe[i] : cfgQ[i]) & CFG_KEEP[i];
    assign padOut[i]    = altEn[i] ? altOut[i] : datQ[i];
    assign padPullEn[i] = ~altEn[i] & ~cfgQ[i] & datQ[i];
  end

endmodule

// File: rtl/gpio_regfile_dp.sv
module gpio_regfile_dp
  import gpio_portbank_pkg::*;
#(
  parameter int           W           = 8,
  parameter int           OUT_W       = 4,
  parameter logic [W-1:0] B_INONLY    = 8'hC0,
  parameter int           SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  input  logic [W-1:0]     padAIn,
  output logic [W-1:0]     padAOe,
  output logic [W-1:0]     padAOut,
  output logic [W-1:0]     padAPullEn,
  input  logic [W-1:0]     altAEn,
  input  logic [W-1:0]     altAOut,
  input  logic [W-1:0]     altAOe,
  input  logic [W-1:0]     padBIn,
  output logic [W-1:0]     padBOe,
  output logic [W-1:0]     padBOut,
  output logic [W-1:0]     padBPullEn,
  input  logic [W-1:0]     altBEn,
  input  logic [W-1:0]     altBOut,
  input  logic [W-1:0]     altBOe,
  output logic [OUT_W-1:0] portCOut
);

  logic [W-1:0] aDat, aCfg, aPin, bDat, bCfg, bPin;

  gpio_port_slice #(.W(W), .INONLY_MASK('0), .SYNC_STAGES(SYNC_STAGES)) u_portA (
    .clk(clk), .rstN(rstN), .wrDat(strb.wrADat), .wrCfg(strb.wrACfg),
    .wdata(wdata), .padIn(padAIn), .altEn(altAEn), .altOut(altAOut), .altOe(altAOe),
    .datQ(aDat), .cfgQ(aCfg), .pinQ(aPin),
    .padOe(padAOe), .padOut(padAOut), .padPullEn(padAPullEn)
  );

  gpio_port_slice #(.W(W), .INONLY_MASK(B_INONLY), .SYNC_STAGES(SYNC_STAGES)) u_portB (
    .clk(clk), .rstN(rstN), .wrDat(strb.wrBDat), .wrCfg(strb.wrBCfg),
    .wdata(wdata), .padIn(padBIn), .altEn(altBEn), .altOut(altBOut), .altOe(altBOe),
    .datQ(bDat), .cfgQ(bCfg), .pinQ(bPin),
    .padOe(padBOe), .padOut(padBOut), .padPullEn(padBPullEn)
  );

  // output-only port, presets high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            portCOut <= '1;
    else if (strb.wrCDat) portCOut <= wdata[OUT_W-1:0];
  end

  always_comb begin
    case (strb.rdSel)
      RD_A_DAT: rdata = aDat;
      RD_A_CFG: rdata = aCfg;
      RD_A_PIN: rdata = aPin;
      RD_B_DAT: rdata = bDat;
      RD_B_CFG: rdata = bCfg;
      RD_B_PIN: rdata = bPin;
      RD_C_DAT: rdata = W'(portCOut);
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_portbank.sv
module gpio_portbank
  import gpio_portbank_pkg::*;
#(
  parameter int                 ADDR_W      = 8,
  parameter int                 W           = 8,
  parameter int                 OUT_W       = 4,
  parameter logic [ADDR_W-1:0] A_BASE      = 8'hD0,
  parameter logic [ADDR_W-1:0] B_BASE      = 8'hD4,
  parameter logic [ADDR_W-1:0] C_ADDR      = 8'hDC,
  parameter logic [W-1:0]      B_INONLY    = 8'hC0,
  parameter int                 HALT_BIT    = 7,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [W-1:0]      busWdata,
  output logic [W-1:0]      busRdata,
  input  logic [W-1:0]      padAIn,
  output logic [W-1:0]      padAOe,
  output logic [W-1:0]      padAOut,
  output logic [W-1:0]      padAPullEn,
  input  logic [W-1:0]      altAEn,
  input  logic [W-1:0]      altAOut,
  input  logic [W-1:0]      altAOe,
  input  logic [W-1:0]      padBIn,
  output logic [W-1:0]      padBOe,
  output logic [W-1:0]      padBOut,
  output logic [W-1:0]      padBPullEn,
  input  logic [W-1:0]      altBEn,
  input  logic [W-1:0]      altBOut,
  input  logic [W-1:0]      altBOe,
  output logic [OUT_W-1:0]  portCOut,
  output logic              haltReq
);

  ctrlStrb_t strb;

  gpio_bus_ctrl #(.ADDR_W(ADDR_W), .A_BASE(A_BASE), .B_BASE(B_BASE), .C_ADDR(C_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
    .haltBitIn(busWdata[HALT_BIT]), .strb(strb), .haltReq(haltReq)
  );

  gpio_regfile_dp #(.W(W), .OUT_W(OUT_W), .B_INONLY(B_INONLY), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .rdata(busRdata),
    .padAIn(padAIn), .padAOe(padAOe), .padAOut(padAOut), .padAPullEn(padAPullEn),
    .altAEn(altAEn), .altAOut(altAOut), .altAOe(altAOe),
    .padBIn(padBIn), .padBOe(padBOe), .padBOut(padBOut), .padBPullEn(padBPullEn),
    .altBEn(altBEn), .altBOut(altBOut), .altBOe(altBOe),
    .portCOut(portCOut)
  );

endmodule

// File: rtl/gpio_portbank_chk.sv
module gpio_portbank_chk #(
  parameter int                 ADDR_W   = 8,
  parameter int                 W        = 8,
  parameter int                 OUT_W    = 4,
  parameter logic [ADDR_W-1:0] A_BASE   = 8'hD0,
  parameter logic [ADDR_W-1:0] B_BASE   = 8'hD4,
  parameter logic [ADDR_W-1:0] C_ADDR   = 8'hDC,
  parameter logic [W-1:0]      B_INONLY = 8'hC0,
  parameter int                 HALT_BIT = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic [W-1:0]      busWdata,
  input logic [W-1:0]      padAOe,
  input logic [W-1:0]      padAOut,
  input logic [W-1:0]      altAEn,
  input logic [W-1:0]      altAOut,
  input logic [W-1:0]      altAOe,
  input logic [W-1:0]      padBOe,
  input logic [OUT_W-1:0]  portCOut,
  input logic              haltReq
);

  localparam logic [ADDR_W-1:0] A_CFG = A_BASE + ADDR_W'(1);

  // R2: a config write shows up as the output enables of non-overridden pins
  a_r2_cfg_to_oe: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == A_CFG) |=> (((padAOe ^ $past(busWdata)) & ~altAEn) == '0));

  // R5: input-only pins never drive
  a_r5_inonly_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    (padBOe & B_INONLY) == '0);

  // R6: a qualifying write raises the halt request next cycle
  a_r6_halt_after_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == B_BASE && busWdata[HALT_BIT]) |=> haltReq);

  // R6: no halt request without a qualifying write one cycle earlier
  a_r6_halt_has_cause: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |-> $past(busWr && busAddr == B_BASE && busWdata[HALT_BIT]));

  // R7: port C follows its write
  a_r7_portc_write: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == C_ADDR) |=> (portCOut == $past(busWdata[OUT_W-1:0])));

  // R9: overridden pins take the peripheral's controls
  a_r9_alt_override: assert property (@(posedge clk) disable iff (!rstN)
    ((((padAOe ^ altAOe) | (padAOut ^ altAOut)) & altAEn) == '0));

endmodule

bind gpio_portbank gpio_portbank_chk #(
  .ADDR_W(ADDR_W), .W(W), .OUT_W(OUT_W), .A_BASE(A_BASE), .B_BASE(B_BASE),
  .C_ADDR(C_ADDR), .B_INONLY(B_INONLY), .HALT_BIT(HALT_BIT)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
  .padAOe(padAOe), .padAOut(padAOut), .altAEn(altAEn), .altAOut(altAOut), .altAOe(altAOe),
  .padBOe(padBOe), .portCOut(portCOut), .haltReq(haltReq)
);

// File: tb/tb_gpio_portbank.sv
`timescale 1ns/1ps
module tb_gpio_portbank;

  localparam int K_RD = 0, K_OEA = 1, K_OUTA = 2, K_PUA = 3, K_OEB = 4, K_C = 5, K_HALT = 6;

  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic [7:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padAIn = '0, altAEn = '0, altAOut = '0, altAOe = '0;
  logic [7:0] padBIn = '0, altBEn = '0, altBOut = '0, altBOe = '0;
  logic [7:0] padAOe, padAOut, padAPullEn, padBOe, padBOut, padBPullEn;
  logic [3:0] portCOut;
  logic       haltReq;

  gpio_portbank dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata),
    .padAIn(padAIn), .padAOe(padAOe), .padAOut(padAOut), .padAPullEn(padAPullEn),
    .altAEn(altAEn), .altAOut(altAOut), .altAOe(altAOe),
    .padBIn(padBIn), .padBOe(padBOe), .padBOut(padBOut), .padBPullEn(padBPullEn),
    .altBEn(altBEn), .altBOut(altBOut), .altBOe(altBOe),
    .portCOut(portCOut), .haltReq(haltReq)
  );

  always #2 clk = ~clk;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } sbItem_t;

  sbItem_t sb[$];
  sbItem_t cur;
  int nCmp = 0;
  int nMis = 0;
  bit done = 0;

  function automatic logic [7:0] sample(int kind);
    case (kind)
      K_RD:    return busRdata;
      K_OEA:   return padAOe;
      K_OUTA:  return padAOut;
      K_PUA:   return padAPullEn;
      K_OEB:   return padBOe;
      K_C:     return {4'h0, portCOut};
      default: return {7'h0, haltReq};
    endcase
  endfunction

  // monitor: consume expectations on the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      cur = sb.pop_front();
      nCmp++;
      if (sample(cur.kind) !== cur.exp) begin
        nMis++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", cur.req, cur.kind,
                 sample(cur.kind), cur.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_v(int kind, logic [7:0] exp, string req);
    sbItem_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    sb.push_back(it);
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    tick();
    busWr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] exp, string req);
    busAddr = a;
    expect_v(K_RD, exp, req);
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nMis++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
      $finish;
    end
  end

  initial begin
    #1 rstN = 1'b0;
    repeat (3) @(posedge clk);
    // R1: values while reset is held
    #1;
    expect_v(K_C, 8'h0F, "R1 portC preset in reset");
    expect_v(K_HALT, 8'h00, "R1 halt low in reset");
    tick();
    rstN = 1'b1;
    tick();
    rd(8'hD0, 8'h00, "R1 A data reset");
    rd(8'hD1, 8'h00, "R1 A cfg reset");
    rd(8'hD4, 8'h00, "R1 B data reset");
    rd(8'hD5, 8'h00, "R1 B cfg reset");
    rd(8'hDC, 8'h0F, "R1 portC reset read");
    expect_v(K_OEA, 8'h00, "R1 A oe reset");
    expect_v(K_PUA, 8'h00, "R1 A pull reset");
    expect_v(K_OEB, 8'h00, "R1 B oe reset");
    expect_v(K_HALT, 8'h00, "R1 halt reset");
    tick();

    // R3, R2: port A registers and mode encoding
    wr(8'hD0, 8'hA5);
    rd(8'hD0, 8'hA5, "R3 A data readback");
    wr(8'hD1, 8'h0F);
    rd(8'hD1, 8'h0F, "R3 A cfg readback");
    expect_v(K_OEA, 8'h0F, "R2 oe follows cfg");
    expect_v(K_OUTA, 8'hA5, "R2 out follows data");
    expect_v(K_PUA, 8'hA0, "R2 pull where cfg0 data1");
    tick();

    // R3: read before write edge is old, after is new
    busAddr = 8'hD0; busWdata = 8'h11; busWr = 1'b1;
    expect_v(K_RD, 8'hA5, "R3 old value before edge");
    tick();
    busWr = 1'b0;
    expect_v(K_RD, 8'h11, "R3 new value after edge");
    tick();
    wr(8'hD0, 8'hA5);

    // R4, R5: port B registers and input-only pins
    wr(8'hD4, 8'h3C);
    rd(8'hD4, 8'h3C, "R4 B data readback");
    wr(8'hD5, 8'hFF);
    rd(8'hD5, 8'h3F, "R5 B cfg bits 7:6 read 0");
    expect_v(K_OEB, 8'h3F, "R5 B oe masked");
    tick();
    altBEn = 8'hFF; altBOe = 8'hFF; altBOut = 8'hFF;
    expect_v(K_OEB, 8'h3F, "R5 B alt cannot drive inputs");
    tick();
    altBEn = 8'h00; altBOe = 8'h00; altBOut = 8'h00;

    // R6: halt pulse
    wr(8'hD4, 8'h80);
    expect_v(K_HALT, 8'h01, "R6 halt pulse high");
    tick();
    expect_v(K_HALT, 8'h00, "R6 halt pulse one cycle");
    rd(8'hD4, 8'h80, "R6 bit7 stored");
    wr(8'hD4, 8'h7F);
    expect_v(K_HALT, 8'h00, "R6 no halt on bit7 clear");
    tick();
    wr(8'hD5, 8'h80);
    expect_v(K_HALT, 8'h00, "R6 no halt from other address");
    rd(8'hD5, 8'h00, "R5 cfg bit7 write dropped");
    wr(8'hD4, 8'h80);

    // R7: output-only port
    wr(8'hDC, 8'hA5);
    expect_v(K_C, 8'h05, "R7 portC drives");
    rd(8'hDC, 8'h05, "R7 portC read zero-extended");

    // R8: pad input sync and read-only locations
    padAIn = 8'h3C;
    rd(8'hD2, 8'h00, "R8 pad not yet visible");
    rd(8'hD2, 8'h00, "R8 pad after one edge");
    rd(8'hD2, 8'h3C, "R8 pad after two edges");
    wr(8'hD2, 8'hFF);
    rd(8'hD0, 8'hA5, "R8 pin write leaves A data");
    rd(8'hD1, 8'h0F, "R8 pin write leaves A cfg");
    rd(8'hD2, 8'h3C, "R8 pin location unchanged");
    padBIn = 8'hC3;
    tick();
    tick();
    rd(8'hD6, 8'hC3, "R8 B pad read");
    wr(8'hD6, 8'h00);
    rd(8'hD4, 8'h80, "R8 B pin write leaves data");

    // R9: alternate override
    altAEn = 8'h0F; altAOe = 8'h05; altAOut = 8'h03;
    expect_v(K_OEA, 8'h05, "R9 alt oe");
    expect_v(K_OUTA, 8'hA3, "R9 alt out");
    expect_v(K_PUA, 8'hA0, "R9 alt pull off");
    tick();
    rd(8'hD2, 8'h3C, "R9 pad read under alt");
    altAEn = 8'h00;

    // R10: unmapped addresses
    rd(8'hD3, 8'h00, "R10 unmapped D3");
    rd(8'hD7, 8'h00, "R10 unmapped D7");
    rd(8'hDD, 8'h00, "R10 unmapped DD");
    rd(8'h10, 8'h00, "R10 unmapped 10");
    wr(8'hD3, 8'hFF);
    wr(8'hD7, 8'hFF);
    rd(8'hD0, 8'hA5, "R10 write leaves A data");
    rd(8'hD4, 8'h80, "R10 write leaves B data");
    rd(8'hDC, 8'h05, "R10 write leaves portC");

    tick();
    tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nMis);
    $finish;
  end

endmodule